// File: doc/BRIEF.md
# Vectored Interrupt Controller for an 8-bit Core

This block arbitrates three interrupt sources for a small 8-bit processor core: a USB event, a timer 0 overflow and a timer 1 overflow. A single 8-bit control word holds everything firmware needs. It has a master enable, one enable per source and one pending flag per source. Firmware writes the whole word through a simple register port, and the word is always visible on the read bus.

Each cycle the controller checks whether any source is enabled, pending and allowed by the master enable, and whether the core's return stack can take one more entry. When one is, the highest-priority source wins. One clock later the controller raises a one-cycle call request carrying that source's fixed vector address. The core pushes only its program counter, and no other state is saved for it. The same clock edge clears the winning flag and the master enable, so nothing else can be taken until firmware or a return strobe enables interrupts again.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Control word layout: bit 0 master enable, bits 1/2/3 enable USB/timer 0/timer 1, bits 4/5/6 pending flag USB/timer 0/timer 1. Bit 7 always reads 0 and ignores writes. A write with `reg_wr_en` loads the word on the next clock edge.
- R2: While `rst` is high at a clock edge, the control word, `call_req` and `call_addr` all become 0.
- R3: A source is accepted only if the master enable, its enable bit and its pending flag are all 1 and `stack_full` is 0 in the same cycle.
- R4: The call address is 0x004 for USB, 0x008 for timer 0 and 0x00C for timer 1.
- R5: When more than one source is eligible, USB beats timer 0 and timer 0 beats timer 1.
- R6: At the acceptance edge, hardware clears the served source's flag and the master enable and leaves all other bits unchanged. This clearing overrides a firmware write made at the same edge.
- R7: `call_req` is high for exactly one cycle, in the cycle after the eligible state. `call_addr` keeps the last vector until the next call.
- R8: A pulse on any of the four `usb_evt` lines (bit 0 FIFO access, 1 suspend, 2 resume, 3 bus reset) sets bit 4. `tmr0_ovf` sets bit 5 and `tmr1_ovf` sets bit 6.
- R9: A hardware set of a pending flag overrides a firmware write of 0, and also overrides an acceptance clear of that flag at the same edge.
- R10: `reti_strobe` sets the master enable at the next edge, unless an acceptance clears it at that same edge.
- R11: While `stack_full` is high, a pending enabled request stays pending. It is taken once `stack_full` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Firmware write strobe for the control word |
| reg_wr_data | input | 8 | Firmware write data |
| reg_rd_data | output | 8 | Current control word |
| usb_evt | input | USB_EVT_W | USB event pulses (FIFO access, suspend, resume, bus reset) |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| stack_full | input | 1 | Core return stack has no free entry |
| reti_strobe | input | 1 | Core executed a return from interrupt |
| call_req | output | 1 | One-cycle subroutine call request |
| call_addr | output | PC_W | Vector address of the call |

## Verification
The bench builds the block with its defaults: an 11-bit program counter, four USB event lines and vectors 0x004, 0x008 and 0x00C. This lets every USB event line be pulsed on its own and every vector be compared at full width. A vector table drives whole control words through all priority mixes. Directed cases then cover the collisions between hardware sets, firmware writes, return strobes and acceptance clears at one edge. They also cover a request that waits behind a full stack.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int CTRL_W  = 8;
    localparam int N_SRC   = 3;
    localparam int GIE_POS = 0;
    localparam int EN_LSB  = 1;
    localparam int FLG_LSB = 4;

    // Field order matches the control word, MSB first.
    typedef struct packed {
        logic             spare;
        logic [N_SRC-1:0] flag;
        logic [N_SRC-1:0] en;
        logic             gie;
    } ctrl_t;

    // Source index doubles as priority: lower index wins.
    typedef enum logic [1:0] {
        SRC_USB  = 2'd0,
        SRC_TMR0 = 2'd1,
        SRC_TMR1 = 2'd2
    } src_e;

    function automatic logic [N_SRC-1:0] pick_first(input logic [N_SRC-1:0] req);
        logic [N_SRC-1:0] g;
        g = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                g    = '0;
                g[i] = 1'b1;
            end
        end
        return g;
    endfunction

endpackage

// File: rtl/irqc_ctrl_reg.sv
module irqc_ctrl_reg
    import irqc_pkg::*;
#(
    parameter int USB_EVT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [CTRL_W-1:0]    wr_data,
    input  logic [USB_EVT_W-1:0] usb_evt,
    input  logic                 tmr0_ovf,
    input  logic                 tmr1_ovf,
    input  logic                 reti,
    input  logic                 accept,
    input  logic [N_SRC-1:0]     grant,
    output ctrl_t                ctrl_q
);

    logic [N_SRC-1:0] hw_set;
    logic [N_SRC-1:0] flag_nx;
    ctrl_t            base;
    ctrl_t            ctrl_d;

    assign hw_set[SRC_USB]  = |usb_evt;
    assign hw_set[SRC_TMR0] = tmr0_ovf;
    assign hw_set[SRC_TMR1] = tmr1_ovf;

    // Firmware write is the lowest-priority update.
    always_comb begin
        base = wr_en ? ctrl_t'(wr_data) : ctrl_q;
        base.spare = 1'b0;
        if (reti)   base.gie = 1'b1;
        if (accept) base.gie = 1'b0;
    end

    // Per-source flag: acceptance clears, hardware set overrides all.
    for (genvar i = 0; i < N_SRC; i++) begin : g_flag
        assign flag_nx[i] = (base.flag[i] & ~(accept & grant[i])) | hw_set[i];
    end

    always_comb begin
        ctrl_d      = base;
        ctrl_d.flag = flag_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
(
    input  ctrl_t            ctrl,
    input  logic             stack_full,
    output logic [N_SRC-1:0] grant,
    output logic             accept
);

    logic             open_gate;
    logic [N_SRC-1:0] eligible;

    assign open_gate = ctrl.gie & ~stack_full;
    assign eligible  = ctrl.en & ctrl.flag & {N_SRC{open_gate}};
    assign grant     = pick_first(eligible);
    assign accept    = |eligible;

endmodule

// File: rtl/irqc_call_gen.sv
module irqc_call_gen
    import irqc_pkg::*;
#(
    parameter int PC_W     = 11,
    parameter int VEC_USB  = 4,
    parameter int VEC_TMR0 = 8,
    parameter int VEC_TMR1 = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [N_SRC-1:0] grant,
    output logic             call_req,
    output logic [PC_W-1:0]  call_addr
);

    localparam logic [PC_W-1:0] VEC_TAB [N_SRC] = '{
        PC_W'(VEC_USB), PC_W'(VEC_TMR0), PC_W'(VEC_TMR1)
    };

    logic [PC_W-1:0] addr_sel;

    // One-hot grant selects a vector by AND-OR.
    always_comb begin
        addr_sel = '0;
        for (int i = 0; i < N_SRC; i++) begin
            addr_sel = addr_sel | (VEC_TAB[i] & {PC_W{grant[i]}});
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            call_req  <= 1'b0;
            call_addr <= '0;
        end else begin
            call_req <= accept;
            if (accept) call_addr <= addr_sel;
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqc_pkg::*;
#(
    parameter int PC_W      = 11,
    parameter int USB_EVT_W = 4,
    parameter int VEC_USB   = 4,
    parameter int VEC_TMR0  = 8,
    parameter int VEC_TMR1  = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr_en,
    input  logic [7:0]           reg_wr_data,
    output logic [7:0]           reg_rd_data,
    input  logic [USB_EVT_W-1:0] usb_evt,
    input  logic                 tmr0_ovf,
    input  logic                 tmr1_ovf,
    input  logic                 stack_full,
    input  logic                 reti_strobe,
    output logic                 call_req,
    output logic [PC_W-1:0]      call_addr
);

    ctrl_t            ctrl_q;
    logic [N_SRC-1:0] grant;
    logic             accept;

    irqc_ctrl_reg #(.USB_EVT_W(USB_EVT_W)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .usb_evt  (usb_evt),
        .tmr0_ovf (tmr0_ovf),
        .tmr1_ovf (tmr1_ovf),
        .reti     (reti_strobe),
        .accept   (accept),
        .grant    (grant),
        .ctrl_q   (ctrl_q)
    );

    irqc_arbiter arb_i (
        .ctrl       (ctrl_q),
        .stack_full (stack_full),
        .grant      (grant),
        .accept     (accept)
    );

    irqc_call_gen #(
        .PC_W     (PC_W),
        .VEC_USB  (VEC_USB),
        .VEC_TMR0 (VEC_TMR0),
        .VEC_TMR1 (VEC_TMR1)
    ) call_i (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .grant     (grant),
        .call_req  (call_req),
        .call_addr (call_addr)
    );

    assign reg_rd_data = ctrl_q;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int PC_W      = 11,
    parameter int USB_EVT_W = 4,
    parameter int VEC_USB   = 4,
    parameter int VEC_TMR0  = 8,
    parameter int VEC_TMR1  = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic [7:0]           reg_rd_data,
    input logic [USB_EVT_W-1:0] usb_evt,
    input logic                 tmr0_ovf,
    input logic                 stack_full,
    input logic                 reti_strobe,
    input logic                 call_req,
    input logic [PC_W-1:0]      call_addr
);

    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !reg_rd_data[7]); // R1

    AST_STACK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        stack_full |=> !call_req); // R3

    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
        call_req |-> (call_addr == PC_W'(VEC_USB) || call_addr == PC_W'(VEC_TMR0)
                      || call_addr == PC_W'(VEC_TMR1))); // R4

    AST_USB_FIRST: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_data[0] && reg_rd_data[1] && reg_rd_data[4] && !stack_full)
        |=> (call_req && call_addr == PC_W'(VEC_USB))); // R5

    AST_GIE_DROPS: assert property (@(posedge clk) disable iff (rst)
        call_req |-> !reg_rd_data[0]); // R6

    AST_CALL_PULSE: assert property (@(posedge clk) disable iff (rst)
        call_req |=> !call_req); // R7

    AST_USB_SETS: assert property (@(posedge clk) disable iff (rst)
        (|usb_evt) |=> reg_rd_data[4]); // R8

    AST_TMR0_WINS: assert property (@(posedge clk) disable iff (rst)
        tmr0_ovf |=> reg_rd_data[5]); // R9

    AST_RETI_GIE: assert property (@(posedge clk) disable iff (rst)
        reti_strobe |=> (reg_rd_data[0] || call_req)); // R10

endmodule

bind irq_vector_ctrl irqc_checker #(
    .PC_W      (PC_W),
    .USB_EVT_W (USB_EVT_W),
    .VEC_USB   (VEC_USB),
    .VEC_TMR0  (VEC_TMR0),
    .VEC_TMR1  (VEC_TMR1)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .reg_rd_data (reg_rd_data),
    .usb_evt     (usb_evt),
    .tmr0_ovf    (tmr0_ovf),
    .stack_full  (stack_full),
    .reti_strobe (reti_strobe),
    .call_req    (call_req),
    .call_addr   (call_addr)
);

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;

    localparam int PC_W = 11;
    localparam int EW   = 4;

    logic            clk = 1'b0;
    logic            rst;
    logic            reg_wr_en;
    logic [7:0]      reg_wr_data;
    logic [7:0]      reg_rd_data;
    logic [EW-1:0]   usb_evt;
    logic            tmr0_ovf;
    logic            tmr1_ovf;
    logic            stack_full;
    logic            reti_strobe;
    logic            call_req;
    logic [PC_W-1:0] call_addr;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_vector_ctrl dut_i (
        .clk         (clk),
        .rst         (rst),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .usb_evt     (usb_evt),
        .tmr0_ovf    (tmr0_ovf),
        .tmr1_ovf    (tmr1_ovf),
        .stack_full  (stack_full),
        .reti_strobe (reti_strobe),
        .call_req    (call_req),
        .call_addr   (call_addr)
    );

    typedef struct packed {
        logic [7:0]      wd;
        logic            sf;
        logic            call;
        logic [PC_W-1:0] addr;
        logic [7:0]      rd;
    } row_t;

    localparam int N_ROWS = 11;
    localparam row_t ROWS [N_ROWS] = '{
        '{8'h13, 1'b0, 1'b1, 11'h004, 8'h02},  // USB alone
        '{8'h25, 1'b0, 1'b1, 11'h008, 8'h04},  // timer 0 alone
        '{8'h49, 1'b0, 1'b1, 11'h00C, 8'h08},  // timer 1 alone
        '{8'h7F, 1'b0, 1'b1, 11'h004, 8'h6E},  // all: USB first
        '{8'h6D, 1'b0, 1'b1, 11'h008, 8'h4C},  // t0 over t1
        '{8'h7E, 1'b0, 1'b0, 11'h000, 8'h7E},  // master off
        '{8'h13, 1'b1, 1'b0, 11'h000, 8'h13},  // stack full
        '{8'h71, 1'b0, 1'b0, 11'h000, 8'h71},  // flags, no enables
        '{8'hFF, 1'b0, 1'b1, 11'h004, 8'h6E},  // bit 7 ignored
        '{8'h59, 1'b0, 1'b1, 11'h00C, 8'h18},  // USB pending but disabled
        '{8'h00, 1'b0, 1'b0, 11'h000, 8'h00}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v, input logic sf);
        reg_wr_en   = 1'b1;
        reg_wr_data = v;
        stack_full  = sf;
        tick();
        reg_wr_en   = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_wr_en = 1'b0; reg_wr_data = '0; usb_evt = '0;
        tmr0_ovf = 1'b0; tmr1_ovf = 1'b0; stack_full = 1'b0; reti_strobe = 1'b0;
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        tick();
        // R2 reset state
        check(reg_rd_data == 8'h00, "R2", "reset word", reg_rd_data, 0);
        check(call_req == 1'b0, "R2", "reset call_req", call_req, 0);
        check(call_addr == '0, "R2", "reset call_addr", call_addr, 0);

        // Table: R1 R3 R4 R5 R6 R7
        for (int r = 0; r < N_ROWS; r++) begin
            wr(ROWS[r].wd, 1'b1);
            stack_full = ROWS[r].sf;
            tick();
            check(call_req == ROWS[r].call, "R3", $sformatf("row %0d call", r),
                  call_req, ROWS[r].call);
            if (ROWS[r].call)
                check(call_addr == ROWS[r].addr, "R4/R5", $sformatf("row %0d addr", r),
                      call_addr, ROWS[r].addr);
            check(reg_rd_data == ROWS[r].rd, "R6/R1", $sformatf("row %0d word", r),
                  reg_rd_data, ROWS[r].rd);
            stack_full = 1'b1;
            tick();
            check(call_req == 1'b0, "R7", $sformatf("row %0d pulse end", r), call_req, 0);
        end

        // R8 each USB event line sets bit 4
        for (int k = 0; k < EW; k++) begin
            wr(8'h00, 1'b1);
            usb_evt = EW'(1) << k;
            tick();
            usb_evt = '0;
            check(reg_rd_data == 8'h10, "R8", $sformatf("usb line %0d", k), reg_rd_data, 8'h10);
        end
        wr(8'h00, 1'b1);
        tmr0_ovf = 1'b1; tick(); tmr0_ovf = 1'b0;
        check(reg_rd_data == 8'h20, "R8", "timer 0 flag", reg_rd_data, 8'h20);
        wr(8'h00, 1'b1);
        tmr1_ovf = 1'b1; tick(); tmr1_ovf = 1'b0;
        check(reg_rd_data == 8'h40, "R8", "timer 1 flag", reg_rd_data, 8'h40);

        // R9 hardware set beats firmware write of 0
        reg_wr_en = 1'b1; reg_wr_data = 8'h00; tmr1_ovf = 1'b1;
        tick();
        reg_wr_en = 1'b0; tmr1_ovf = 1'b0;
        check(reg_rd_data == 8'h40, "R9", "set vs write", reg_rd_data, 8'h40);
        wr(8'h00, 1'b1);
        check(reg_rd_data == 8'h00, "R1", "plain clear", reg_rd_data, 0);

        // R9 hardware set beats acceptance clear
        wr(8'h25, 1'b1);
        stack_full = 1'b0; tmr0_ovf = 1'b1;
        tick();
        tmr0_ovf = 1'b0; stack_full = 1'b1;
        check(call_req && call_addr == 11'h008, "R9", "call during set", call_addr, 8);
        check(reg_rd_data == 8'h24, "R9", "flag kept", reg_rd_data, 8'h24);

        // R10 return strobe restores master enable
        wr(8'h00, 1'b1);
        reti_strobe = 1'b1; tick(); reti_strobe = 1'b0;
        check(reg_rd_data == 8'h01, "R10", "reti sets gie", reg_rd_data, 1);

        // R11 request waits behind a full stack
        wr(8'h25, 1'b1);
        for (int w = 0; w < 3; w++) begin
            tick();
            check(call_req == 1'b0, "R11", "held while full", call_req, 0);
        end
        check(reg_rd_data == 8'h25, "R11", "still pending", reg_rd_data, 8'h25);
        stack_full = 1'b0;
        tick();
        stack_full = 1'b1;
        check(call_req && call_addr == 11'h008, "R11", "taken after free", call_addr, 8);
        check(reg_rd_data == 8'h04, "R11", "word after", reg_rd_data, 4);

        // R6 acceptance beats same-edge firmware write
        wr(8'h13, 1'b1);
        wr(8'h13, 1'b0);
        stack_full = 1'b1;
        check(call_req && call_addr == 11'h004, "R6", "call on write edge", call_addr, 4);
        check(reg_rd_data == 8'h02, "R6", "clear beats write", reg_rd_data, 2);

        // R2 reset mid-run
        rst = 1'b1; tick(); rst = 1'b0; tick();
        check(reg_rd_data == 8'h00 && call_addr == '0, "R2", "reset again", reg_rd_data, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule